// File: doc/BRIEF.md
# Slave Port Arbiter with Priority Elevation

This block picks one owner among up to `N_MASTERS` masters competing for a single shared slave port. Every master drives a request line and an elevation line. The port runs in one of two base modes. In fixed-priority mode the programmed 3-bit level decides the winner. In round-robin mode a rotating pointer decides it. An elevated master can override either base mode, provided its enable bit is set. In round-robin mode such a master pushes the port into fixed-priority order for as long as any enabled elevated master keeps requesting. When elevation ends, rotation continues from the master that last held the port.

Two complete configuration sets arrive as input vectors: a primary set and an alternate set. Each set holds the levels, the elevation enables and the mode bit. A per-port select line chooses between the two sets, so the port can change context without reprogramming. The grant is registered. A new decision is made only when there is no owner or the current owner drops its request, so a master is never preempted partway through a transfer.

Top module: `spa_arbiter`

## Requirements
- R1: After reset, `grant` is all zeros, `grant_vld` is 0 and `grant_idx` is 0. The rotation pointer starts on the highest-numbered master, so the first round-robin search starts at master 0.
- R2: `grant` is zero or one-hot. Bit i of `grant` is set exactly when `grant_vld` is 1 and `grant_idx` equals i. A grant only goes to a master that was requesting in the cycle before it appeared.
- R3: Outputs are registered. A request presented in cycle t can first show on `grant` after the clock edge that ends cycle t, and never in the same cycle.
- R4: While the current owner keeps its request high, `grant` stays unchanged, whatever the other requests, elevations or configuration inputs do.
- R5: In fixed-priority mode with no effective elevation, the requester with the numerically highest level wins. Master i's level is bits [3i+2:3i] of the level vector.
- R6: In round-robin mode with no effective elevation, the search starts at the master after the pointer and moves upward, wrapping from the highest-numbered master to 0. The pointer takes the index of every master that is granted.
- R7: Elevation counts for master i only when bit i of the selected enable vector is 1. Otherwise the elevation line has no effect on the choice of winner.
- R8: Any requester with effective elevation beats every requester without it, in both modes. Among several such requesters, the highest level wins. In round-robin mode this is a temporary fixed-priority decision.
- R9: Once no enabled elevated master is requesting, round-robin resumes from the last granted master. That master may be the one that was elevated.
- R10: When `sel_alt` is 0 the primary levels, enables and mode bit are used. When it is 1 the alternate ones are used.
- R11: When no master requests, the next cycle has no grant and the rotation pointer is left unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req | input | N_MASTERS | Request line of each master |
| elev | input | N_MASTERS | Elevation line of each master |
| sel_alt | input | 1 | 0 selects the primary configuration, 1 selects the alternate |
| lvl_pri | input | N_MASTERS*LVL_W | Primary levels; master i in bits [LVL_W*i +: LVL_W] |
| lvl_alt | input | N_MASTERS*LVL_W | Alternate levels, same layout |
| elev_en_pri | input | N_MASTERS | Primary elevation enables |
| elev_en_alt | input | N_MASTERS | Alternate elevation enables |
| rr_mode_pri | input | 1 | Primary mode: 1 is round-robin, 0 is fixed |
| rr_mode_alt | input | 1 | Alternate mode: 1 is round-robin, 0 is fixed |
| grant | output | N_MASTERS | Registered one-hot grant |
| grant_idx | output | IDX_W | Index of the granted master |
| grant_vld | output | 1 | A grant is active |

## Verification
The bench builds the arbiter with `N_MASTERS = 4` and `LVL_W = 3`. That size is small enough to sweep every request pattern against every elevation pattern under both configuration sets and both base modes, with an idle cycle between patterns so that each one gets a fresh decision. A deterministic pseudo-random phase without idle cycles then exercises ownership hold, pointer wrap and changes of set while a master owns the port. Directed sequences cover the return to rotation after elevation and the one-cycle grant latency.

// File: rtl/spa_pkg.sv
package spa_pkg;

    typedef enum logic [2:0] {
        PICK_NONE  = 3'd0,
        PICK_HOLD  = 3'd1,
        PICK_ELEV  = 3'd2,
        PICK_FIXED = 3'd3,
        PICK_RR    = 3'd4
    } pick_path_e;

endpackage

// File: rtl/spa_cfg_sel.sv
module spa_cfg_sel #(
    parameter int N_MASTERS = 8,
    parameter int LVL_W     = 3
) (
    input  logic                         sel_alt,
    input  logic [N_MASTERS*LVL_W-1:0]   lvl_pri,
    input  logic [N_MASTERS*LVL_W-1:0]   lvl_alt,
    input  logic [N_MASTERS-1:0]         en_pri,
    input  logic [N_MASTERS-1:0]         en_alt,
    input  logic                         rr_pri,
    input  logic                         rr_alt,
    output logic [N_MASTERS*LVL_W-1:0]   lvl_eff,
    output logic [N_MASTERS-1:0]         en_eff,
    output logic                         rr_eff
);

    // Context choice applied per master slice
    for (genvar g = 0; g < N_MASTERS; g++) begin : g_slice
        assign lvl_eff[g*LVL_W +: LVL_W] = sel_alt ? lvl_alt[g*LVL_W +: LVL_W]
                                                   : lvl_pri[g*LVL_W +: LVL_W];
        assign en_eff[g] = sel_alt ? en_alt[g] : en_pri[g];
    end

    assign rr_eff = sel_alt ? rr_alt : rr_pri;

endmodule

// File: rtl/spa_fixed_pick.sv
module spa_fixed_pick #(
    parameter int N_MASTERS = 8,
    parameter int LVL_W     = 3,
    localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0]         mask,
    input  logic [N_MASTERS*LVL_W-1:0]   lvl,
    output logic                         found,
    output logic [IDX_W-1:0]             idx
);

    logic [LVL_W-1:0] best_lvl;

    // Highest numeric level among masked masters; levels are distinct
    always_comb begin
        found    = 1'b0;
        idx      = '0;
        best_lvl = '0;
        for (int i = 0; i < N_MASTERS; i++) begin
            if (mask[i] && (!found || (lvl[i*LVL_W +: LVL_W] > best_lvl))) begin
                found    = 1'b1;
                idx      = IDX_W'(i);
                best_lvl = lvl[i*LVL_W +: LVL_W];
            end
        end
    end

endmodule

// File: rtl/spa_rr_pick.sv
module spa_rr_pick #(
    parameter int N_MASTERS = 8,
    localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic [N_MASTERS-1:0] mask,
    input  logic [IDX_W-1:0]     ptr,
    output logic                 found,
    output logic [IDX_W-1:0]     idx
);

    // Upward search starting one past the pointer, wrapping once around
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int k = 1; k <= N_MASTERS; k++) begin
            int c;
            c = int'(ptr) + k;
            if (c >= N_MASTERS) c = c - N_MASTERS;
            if (!found && mask[c]) begin
                found = 1'b1;
                idx   = IDX_W'(c);
            end
        end
    end

endmodule

// File: rtl/spa_arbiter.sv
module spa_arbiter
    import spa_pkg::*;
#(
    parameter int N_MASTERS = 8,
    parameter int LVL_W     = 3,
    localparam int IDX_W    = (N_MASTERS > 1) ? $clog2(N_MASTERS) : 1
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [N_MASTERS-1:0]         req,
    input  logic [N_MASTERS-1:0]         elev,
    input  logic                         sel_alt,
    input  logic [N_MASTERS*LVL_W-1:0]   lvl_pri,
    input  logic [N_MASTERS*LVL_W-1:0]   lvl_alt,
    input  logic [N_MASTERS-1:0]         elev_en_pri,
    input  logic [N_MASTERS-1:0]         elev_en_alt,
    input  logic                         rr_mode_pri,
    input  logic                         rr_mode_alt,
    output logic [N_MASTERS-1:0]         grant,
    output logic [IDX_W-1:0]             grant_idx,
    output logic                         grant_vld
);

    typedef struct packed {
        logic                 vld;
        logic [N_MASTERS-1:0] gnt;
        logic [IDX_W-1:0]     idx;
        logic [IDX_W-1:0]     ptr;
    } arb_state_t;

    arb_state_t st_d, st_q;

    logic [N_MASTERS*LVL_W-1:0] lvl_eff;
    logic [N_MASTERS-1:0]       en_eff;
    logic                       rr_eff;
    logic [N_MASTERS-1:0]       elev_eff;
    logic [N_MASTERS-1:0]       fix_mask;
    logic                       fix_found, rr_found;
    logic [IDX_W-1:0]           fix_idx, rr_idx;
    logic                       owner_keeps;
    pick_path_e                 path_d;

    spa_cfg_sel #(.N_MASTERS(N_MASTERS), .LVL_W(LVL_W)) cfg_i (
        .sel_alt (sel_alt),
        .lvl_pri (lvl_pri),
        .lvl_alt (lvl_alt),
        .en_pri  (elev_en_pri),
        .en_alt  (elev_en_alt),
        .rr_pri  (rr_mode_pri),
        .rr_alt  (rr_mode_alt),
        .lvl_eff (lvl_eff),
        .en_eff  (en_eff),
        .rr_eff  (rr_eff)
    );

    assign elev_eff = req & elev & en_eff;
    // Elevated requesters form their own tier; otherwise all requesters compete
    assign fix_mask = (|elev_eff) ? elev_eff : req;

    spa_fixed_pick #(.N_MASTERS(N_MASTERS), .LVL_W(LVL_W)) fix_i (
        .mask  (fix_mask),
        .lvl   (lvl_eff),
        .found (fix_found),
        .idx   (fix_idx)
    );

    spa_rr_pick #(.N_MASTERS(N_MASTERS)) rr_i (
        .mask  (req),
        .ptr   (st_q.ptr),
        .found (rr_found),
        .idx   (rr_idx)
    );

    assign owner_keeps = st_q.vld && req[st_q.idx];

    always_comb begin
        st_d   = st_q;
        path_d = PICK_NONE;
        if (owner_keeps)          path_d = PICK_HOLD;
        else if (|elev_eff)       path_d = PICK_ELEV;
        else if (!(|req))         path_d = PICK_NONE;
        else if (rr_eff)          path_d = PICK_RR;
        else                      path_d = PICK_FIXED;

        case (path_d)
            PICK_HOLD: ;
            PICK_ELEV, PICK_FIXED: begin
                st_d.vld = fix_found;
                st_d.idx = fix_idx;
                st_d.gnt = N_MASTERS'(1) << fix_idx;
                st_d.ptr = fix_idx;
            end
            PICK_RR: begin
                st_d.vld = rr_found;
                st_d.idx = rr_idx;
                st_d.gnt = N_MASTERS'(1) << rr_idx;
                st_d.ptr = rr_idx;
            end
            default: begin
                st_d.vld = 1'b0;
                st_d.idx = '0;
                st_d.gnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q     <= '0;
            st_q.ptr <= IDX_W'(N_MASTERS - 1);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant     = st_q.gnt;
    assign grant_idx = st_q.idx;
    assign grant_vld = st_q.vld;

    // R2: one-hot grant agreeing with the valid flag
    assert_grant_onehot_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant) && (grant_vld == (|grant)));

    // R2: a fresh grant goes to a master that was requesting
    assert_grant_to_requester_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_keeps && (|req)) |=> grant_vld && ((grant & $past(req)) != '0));

    // R4: no preemption while the owner still requests
    assert_hold_owner_R4: assert property (@(posedge clk) disable iff (!rst_n)
        owner_keeps |=> $stable(grant) && $stable(grant_idx) && grant_vld);

    // R8: an effective elevated requester wins a fresh decision
    assert_elev_wins_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (!owner_keeps && (|elev_eff)) |=> ((grant & $past(elev_eff)) != '0));

    // R11: idle port drops its grant and holds the pointer
    assert_idle_no_grant_R11: assert property (@(posedge clk) disable iff (!rst_n)
        !(|req) |=> !grant_vld && $stable(st_q.ptr));

endmodule

// File: tb/spa_arbiter_tb_top.sv
module spa_arbiter_tb_top;

    localparam int N  = 4;
    localparam int LW = 3;
    localparam int IW = 2;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  req = '0;
    logic [N-1:0]  elev = '0;
    logic          sel_alt = 1'b0;
    logic [N*LW-1:0] lvl_pri, lvl_alt;
    logic [N-1:0]  en_pri, en_alt;
    logic          rr_pri = 1'b0, rr_alt = 1'b0;
    logic [N-1:0]  grant;
    logic [IW-1:0] grant_idx;
    logic          grant_vld;

    // Levels per master index 0..3
    int lv_p [N] = '{1, 5, 3, 7};
    int lv_a [N] = '{6, 2, 4, 0};

    assign lvl_pri = {3'd7, 3'd3, 3'd5, 3'd1};
    assign lvl_alt = {3'd0, 3'd4, 3'd2, 3'd6};
    assign en_pri  = 4'b0101;
    assign en_alt  = 4'b1110;

    always #2.5 clk = ~clk;

    spa_arbiter #(.N_MASTERS(N), .LVL_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .req(req), .elev(elev), .sel_alt(sel_alt),
        .lvl_pri(lvl_pri), .lvl_alt(lvl_alt),
        .elev_en_pri(en_pri), .elev_en_alt(en_alt),
        .rr_mode_pri(rr_pri), .rr_mode_alt(rr_alt),
        .grant(grant), .grant_idx(grant_idx), .grant_vld(grant_vld)
    );

    int checks = 0;
    int fails  = 0;

    // Reference state
    bit m_vld = 0;
    int m_idx = 0;
    int m_ptr = N - 1;

    task automatic chk(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    function automatic int best_level(input logic [N-1:0] m, input bit alt);
        int w = -1;
        int wl = -1;
        for (int i = 0; i < N; i++) begin
            int l = alt ? lv_a[i] : lv_p[i];
            if (m[i] && l > wl) begin wl = l; w = i; end
        end
        return w;
    endfunction

    // One cycle: drive at negedge, model, compare at following negedge
    task automatic step(input logic [N-1:0] r, input logic [N-1:0] e, input string tag_in);
        string tag;
        logic [N-1:0] en, ee;
        bit rr;
        int w;
        en = sel_alt ? en_alt : en_pri;
        rr = sel_alt ? rr_alt : rr_pri;
        ee = r & e & en;
        if (m_vld && r[m_idx]) begin
            tag = "R4";
        end else if (ee != 0) begin
            tag = "R8"; w = best_level(ee, sel_alt);
            m_vld = 1; m_idx = w; m_ptr = w;
        end else if (r == 0) begin
            tag = "R11"; m_vld = 0; m_idx = 0;
        end else if (!rr) begin
            tag = "R5"; w = best_level(r, sel_alt);
            m_vld = 1; m_idx = w; m_ptr = w;
        end else begin
            tag = "R6"; w = -1;
            for (int k = 1; k <= N; k++) begin
                if (w < 0 && r[(m_ptr + k) % N]) w = (m_ptr + k) % N;
            end
            m_vld = 1; m_idx = w; m_ptr = w;
        end
        if (tag_in != "") tag = tag_in;
        req = r; elev = e;
        @(posedge clk);
        @(negedge clk);
        begin
            logic [N-1:0] eg;
            eg = m_vld ? (N'(1) << m_idx) : '0;
            chk(grant == eg && grant_vld == m_vld && int'(grant_idx) == (m_vld ? m_idx : 0),
                tag, $sformatf("g=%b v=%0d i=%0d", grant, grant_vld, grant_idx),
                $sformatf("g=%b v=%0d i=%0d", eg, m_vld, m_vld ? m_idx : 0));
            // R2: grant consistency at the ports
            chk($countones(grant) <= 1 && (grant_vld == (grant != 0)), "R2",
                $sformatf("g=%b v=%0d", grant, grant_vld), "onehot0 consistent");
        end
    endtask

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin : main
        logic [15:0] lfsr;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(grant == 0 && !grant_vld && grant_idx == 0, "R1",
            $sformatf("g=%b v=%0d i=%0d", grant, grant_vld, grant_idx), "g=0000 v=0 i=0");

        // R3 and R1: first round-robin grant goes to master 0, one cycle late
        rr_pri = 1'b1;
        req = 4'b1111;
        #1;
        chk(!grant_vld, "R3", $sformatf("v=%0d", grant_vld), "v=0");
        step(4'b1111, 4'b0000, "R1");
        step(4'b0000, 4'b0000, "");

        // R9: elevation forces fixed order, then rotation resumes after the elevated master
        step(4'b1111, 4'b0100, "R8");   // master 2 elevated, enabled in primary
        step(4'b1011, 4'b0000, "R9");   // owner 2 drops: next after 2 is 3
        step(4'b0011, 4'b0000, "R9");   // 3 drops: wraps to 0
        step(4'b0000, 4'b0000, "");

        // R7: elevation of master 1 is disabled in primary set, rotation decides
        step(4'b1110, 4'b0010, "R7");   // pointer 0 -> master 1 by rotation anyway
        step(4'b0000, 4'b0000, "");
        step(4'b1100, 4'b1000, "R7");   // 3 elevated but disabled: rotation from 1 gives 2
        step(4'b0000, 4'b0000, "");

        // R10: set selection in fixed mode
        rr_pri = 1'b0; rr_alt = 1'b0;
        sel_alt = 1'b0;
        step(4'b1111, 4'b0000, "R10");  // primary: master 3
        step(4'b0000, 4'b0000, "");
        sel_alt = 1'b1;
        step(4'b1111, 4'b0000, "R10");  // alternate: master 0
        step(4'b0000, 4'b0000, "");

        // Sweep: every request x elevation pattern, both sets, both modes
        for (int s = 0; s < 2; s++) begin
            for (int md = 0; md < 2; md++) begin
                sel_alt = s[0];
                rr_pri = md[0];
                rr_alt = ~md[0];
                for (int r = 0; r < 16; r++) begin
                    for (int e = 0; e < 16; e++) begin
                        step(4'(r), 4'(e), "");
                        step(4'b0000, 4'b0000, "");
                    end
                end
            end
        end

        // Pseudo-random phase without idle gaps: hold, wrap, context changes
        lfsr = 16'hACE1;
        for (int n = 0; n < 1500; n++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            sel_alt = lfsr[9];
            rr_pri  = lfsr[11];
            rr_alt  = lfsr[14];
            step(lfsr[3:0], lfsr[7:4] & {4{lfsr[8]}}, "");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule